// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer for 4 KB pages. A lookup presents an address-space tag, a virtual address (page number plus 12-bit page offset) and an access type. In the same cycle the block answers with a hit flag, the physical address, a modify fault for writes to clean pages and, on a miss, a refill request that carries the tag and page number a handler must fetch.

Entries are installed through a write port. Each write goes either to the slot held in a programmable slot-pointer register or to the slot held in a free-running victim register. The victim register counts down once per clock. It never goes below a programmable floor, so the slots under the floor stay pinned for translations that must not be evicted. Each entry keeps a reference flag. Any completed access sets it, and one clear input wipes all of them, which gives an approximate recency measure. A probe port reads back the valid flag, reference flag and page number of any slot.

Top module: `asid_tlb`

## Requirements
- R1: During and after reset every slot is invalid (probeValid = 0, probeRef = 0) and randomIdx equals NUM_SLOTS-1.
- R2: A lookup hits when a valid slot holds the presented VPN (lkVaddr[31:12]) and the same ASID. In the same cycle lkHit = 1 and lkPaddr = {stored PPN, lkVaddr[11:0]}.
- R3: A slot whose ASID differs from lkAsid does not hit unless its global flag is set. A global slot hits for any ASID.
- R4: When lkValid = 1 and no slot hits, refillReq = 1 in the same cycle, with refillAsid = lkAsid and refillVpn = lkVaddr[31:12]. refillReq and lkHit are never 1 together, and both are 0 when lkValid = 0.
- R5: With insEn = 1 and insRandom = 0, the entry is written at the clock edge into the slot held in the slot-pointer register. That register loads idxWrData at the edge where idxWrEn = 1.
- R6: With insEn = 1 and insRandom = 1, the entry is written into the slot shown on randomIdx in that cycle.
- R7: randomIdx drops by one every cycle. In the cycle after it equals the floor register, it shows NUM_SLOTS-1. It is never below the floor.
- R8: A floor write (wiredWrEn = 1) loads wiredWrData into the floor register and sets randomIdx to NUM_SLOTS-1 in the next cycle.
- R9: A write lookup (lkWrite = 1) that hits a slot whose dirty flag is 0 raises lkModFault while lkHit stays 1, and does not set the reference flag. A read lookup never raises lkModFault.
- R10: A hit without a modify fault sets the matched slot's reference flag at the next clock edge. Installing an entry clears its reference flag.
- R11: refClear = 1 clears every reference flag at the next edge. This takes priority over a flag being set by an access in the same cycle.
- R12: A slot installed with insValid = 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkWrite | input | 1 | Lookup is a write access |
| lkAsid | input | 8 | Address-space tag of the lookup |
| lkVaddr | input | 32 | Virtual address: VPN in [31:12], offset in [11:0] |
| lkHit | output | 1 | Lookup matched a slot |
| lkPaddr | output | 32 | Physical address {PPN, offset}; 0 on miss |
| lkModFault | output | 1 | Write to a clean page |
| refillReq | output | 1 | Miss, refill needed |
| refillAsid | output | 8 | Tag of the missing translation |
| refillVpn | output | 20 | Page number of the missing translation |
| insEn | input | 1 | Install an entry |
| insRandom | input | 1 | 1: victim slot, 0: pointer slot |
| insAsid | input | 8 | Tag of the new entry |
| insVpn | input | 20 | Page number of the new entry |
| insPpn | input | 20 | Physical page of the new entry |
| insValid | input | 1 | Valid flag of the new entry |
| insDirty | input | 1 | Dirty (writable) flag of the new entry |
| insGlobal | input | 1 | Global flag of the new entry |
| idxWrEn | input | 1 | Load the slot-pointer register |
| idxWrData | input | log2(NUM_SLOTS) | Slot-pointer value |
| wiredWrEn | input | 1 | Load the floor register |
| wiredWrData | input | log2(NUM_SLOTS) | Floor value |
| refClear | input | 1 | Clear all reference flags |
| randomIdx | output | log2(NUM_SLOTS) | Current victim slot |
| probeSlot | input | log2(NUM_SLOTS) | Slot to read back |
| probeValid | output | 1 | Valid flag of the probed slot |
| probeRef | output | 1 | Reference flag of the probed slot |
| probeVpn | output | 20 | Page number of the probed slot |

## Verification
On every cycle the assertions check the victim register: it stays at or above the floor, steps down by exactly one, and restarts at the top after a floor write. They also check that a miss and a hit are never reported together, that a modify fault only comes with a write hit, that a clear leaves no reference flag set, and that a freshly installed slot has no reference flag. The translation results themselves can only be shown by the bench's scenarios. That covers tag-sensitive and global matching, the exact physical address, which slot an indexed or random install lands in, and the ordering between a clear and an access in the same cycle.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 20;
  localparam int OFF_W  = 12;
  localparam int PPN_W  = 20;

  typedef struct packed {
    logic              valid;
    logic              global;
    logic              dirty;
    logic              refd;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlbEntry_t;

  typedef struct packed {
    logic install;
    logic markRef;
    logic clearRefs;
  } tlbStrobe_t;
endpackage

// File: rtl/asid_tlb_dp.sv
module asid_tlb_dp
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [IDX_W-1:0]  insSlot,
  input  tlbEntry_t         insEntry,
  input  logic              lkValid,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [IDX_W-1:0]  probeSlot,
  output logic              matchHit,
  output logic [IDX_W-1:0]  hitSlot,
  output logic [PPN_W-1:0]  hitPpn,
  output logic              hitDirty,
  output logic              probeValid,
  output logic              probeRef,
  output logic [VPN_W-1:0]  probeVpn
);
  tlbEntry_t              tbl [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]   slotMatch;
  logic [NUM_SLOTS-1:0]   refVec;

  // one comparator per slot: valid, page number, and tag unless global
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign slotMatch[g] = tbl[g].valid && (tbl[g].vpn == lkVpn) &&
                          (tbl[g].global || (tbl[g].asid == lkAsid));
    assign refVec[g]    = tbl[g].refd;
  end

  // lowest matching slot wins
  always_comb begin
    hitSlot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slotMatch[i]) hitSlot = IDX_W'(i);
    end
  end

  assign matchHit   = lkValid && (slotMatch != '0);
  assign hitPpn     = tbl[hitSlot].ppn;
  assign hitDirty   = tbl[hitSlot].dirty;
  assign probeValid = tbl[probeSlot].valid;
  assign probeRef   = tbl[probeSlot].refd;
  assign probeVpn   = tbl[probeSlot].vpn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (strobe.clearRefs)
          tbl[i].refd <= 1'b0;
        else if (strobe.markRef && (hitSlot == IDX_W'(i)))
          tbl[i].refd <= 1'b1;
      end
      if (strobe.install) tbl[insSlot] <= insEntry;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRefs |=> (refVec == '0)); // R11

  AST_INSTALL_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.install |=> !refVec[$past(insSlot)]); // R10
endmodule

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             lkWrite,
  input  logic             matchHit,
  input  logic             hitDirty,
  input  logic             insEn,
  input  logic             insRandom,
  input  logic             idxWrEn,
  input  logic [IDX_W-1:0] idxWrData,
  input  logic             wiredWrEn,
  input  logic [IDX_W-1:0] wiredWrData,
  input  logic             refClear,
  output tlbStrobe_t       strobe,
  output logic [IDX_W-1:0] insSlot,
  output logic [IDX_W-1:0] randomIdx,
  output logic             lkModFault,
  output logic             refillReq
);
  localparam logic [IDX_W-1:0] TOP_SLOT = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] wiredReg;
  logic [IDX_W-1:0] rndReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg   <= '0;
      wiredReg <= '0;
      rndReg   <= TOP_SLOT;
    end else begin
      if (idxWrEn) idxReg <= idxWrData;
      if (wiredWrEn) begin
        wiredReg <= wiredWrData;
        rndReg   <= TOP_SLOT;
      end else if (rndReg <= wiredReg) begin
        rndReg <= TOP_SLOT;
      end else begin
        rndReg <= rndReg - 1'b1;
      end
    end
  end

  always_comb begin
    insSlot          = insRandom ? rndReg : idxReg;
    lkModFault       = matchHit && lkWrite && !hitDirty;
    refillReq        = lkValid && !matchHit;
    strobe.install   = insEn;
    strobe.clearRefs = refClear;
    strobe.markRef   = matchHit && !lkModFault;
  end

  assign randomIdx = rndReg;

  AST_RANDOM_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    rndReg >= wiredReg); // R7

  AST_RANDOM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!wiredWrEn && (rndReg > wiredReg)) |=> (rndReg == $past(rndReg) - 1'b1)); // R7

  AST_WIRED_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    wiredWrEn |=> (rndReg == TOP_SLOT)); // R8

  AST_FAULT_ON_WRITE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    lkModFault |-> (matchHit && lkWrite)); // R9
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic                   lkWrite,
  input  logic [ASID_W-1:0]      lkAsid,
  input  logic [VPN_W+OFF_W-1:0] lkVaddr,
  output logic                   lkHit,
  output logic [PPN_W+OFF_W-1:0] lkPaddr,
  output logic                   lkModFault,
  output logic                   refillReq,
  output logic [ASID_W-1:0]      refillAsid,
  output logic [VPN_W-1:0]       refillVpn,
  input  logic                   insEn,
  input  logic                   insRandom,
  input  logic [ASID_W-1:0]      insAsid,
  input  logic [VPN_W-1:0]       insVpn,
  input  logic [PPN_W-1:0]       insPpn,
  input  logic                   insValid,
  input  logic                   insDirty,
  input  logic                   insGlobal,
  input  logic                   idxWrEn,
  input  logic [IDX_W-1:0]       idxWrData,
  input  logic                   wiredWrEn,
  input  logic [IDX_W-1:0]       wiredWrData,
  input  logic                   refClear,
  output logic [IDX_W-1:0]       randomIdx,
  input  logic [IDX_W-1:0]       probeSlot,
  output logic                   probeValid,
  output logic                   probeRef,
  output logic [VPN_W-1:0]       probeVpn
);
  tlbStrobe_t       strobe;
  tlbEntry_t        insEntry;
  logic [IDX_W-1:0] insSlot;
  logic [IDX_W-1:0] hitSlot;
  logic [PPN_W-1:0] hitPpn;
  logic             matchHit;
  logic             hitDirty;
  logic [VPN_W-1:0] lkVpn;

  assign lkVpn = lkVaddr[OFF_W +: VPN_W];

  always_comb begin
    insEntry        = '0;
    insEntry.valid  = insValid;
    insEntry.global = insGlobal;
    insEntry.dirty  = insDirty;
    insEntry.asid   = insAsid;
    insEntry.vpn    = insVpn;
    insEntry.ppn    = insPpn;
  end

  asid_tlb_ctrl #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .matchHit(matchHit), .hitDirty(hitDirty), .insEn(insEn),
    .insRandom(insRandom), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .wiredWrEn(wiredWrEn), .wiredWrData(wiredWrData), .refClear(refClear),
    .strobe(strobe), .insSlot(insSlot), .randomIdx(randomIdx),
    .lkModFault(lkModFault), .refillReq(refillReq)
  );

  asid_tlb_dp #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insSlot(insSlot),
    .insEntry(insEntry), .lkValid(lkValid), .lkAsid(lkAsid), .lkVpn(lkVpn),
    .probeSlot(probeSlot), .matchHit(matchHit), .hitSlot(hitSlot),
    .hitPpn(hitPpn), .hitDirty(hitDirty), .probeValid(probeValid),
    .probeRef(probeRef), .probeVpn(probeVpn)
  );

  assign lkHit      = matchHit;
  assign lkPaddr    = matchHit ? {hitPpn, lkVaddr[OFF_W-1:0]} : '0;
  assign refillAsid = lkAsid;
  assign refillVpn  = lkVpn;

  AST_MISS_XOR_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !(refillReq && lkHit)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !refillReq)); // R4
endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int N = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 0, lkWrite = 0;
  logic [7:0] lkAsid = '0;
  logic [31:0] lkVaddr = '0;
  logic lkHit, lkModFault, refillReq;
  logic [31:0] lkPaddr;
  logic [7:0] refillAsid;
  logic [19:0] refillVpn;
  logic insEn = 0, insRandom = 0, insValid = 0, insDirty = 0, insGlobal = 0;
  logic [7:0] insAsid = '0;
  logic [19:0] insVpn = '0, insPpn = '0;
  logic idxWrEn = 0, wiredWrEn = 0, refClear = 0;
  logic [IW-1:0] idxWrData = '0, wiredWrData = '0, probeSlot = '0;
  logic [IW-1:0] randomIdx;
  logic probeValid, probeRef;
  logic [19:0] probeVpn;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  int wiredModel = 0;

  logic sHit, sFault, sReq;
  logic [31:0] sPaddr;
  logic [7:0] sRAsid;
  logic [19:0] sRVpn;

  always #2 clk = ~clk;

  asid_tlb #(.NUM_SLOTS(N)) uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .lkAsid(lkAsid), .lkVaddr(lkVaddr), .lkHit(lkHit), .lkPaddr(lkPaddr),
    .lkModFault(lkModFault), .refillReq(refillReq), .refillAsid(refillAsid),
    .refillVpn(refillVpn), .insEn(insEn), .insRandom(insRandom),
    .insAsid(insAsid), .insVpn(insVpn), .insPpn(insPpn), .insValid(insValid),
    .insDirty(insDirty), .insGlobal(insGlobal), .idxWrEn(idxWrEn),
    .idxWrData(idxWrData), .wiredWrEn(wiredWrEn), .wiredWrData(wiredWrData),
    .refClear(refClear), .randomIdx(randomIdx), .probeSlot(probeSlot),
    .probeValid(probeValid), .probeRef(probeRef), .probeVpn(probeVpn)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setIndex(int v);
    @(negedge clk); idxWrEn = 1; idxWrData = IW'(v);
    @(negedge clk); idxWrEn = 0;
  endtask

  task automatic setWired(int v);
    @(negedge clk); wiredWrEn = 1; wiredWrData = IW'(v);
    @(negedge clk); wiredWrEn = 0; wiredModel = v;
  endtask

  task automatic install(bit rnd, logic [7:0] a, logic [19:0] v, logic [19:0] p,
                         bit vld, bit dty, bit glb);
    @(negedge clk);
    insEn = 1; insRandom = rnd; insAsid = a; insVpn = v; insPpn = p;
    insValid = vld; insDirty = dty; insGlobal = glb;
    @(negedge clk); insEn = 0; insRandom = 0;
  endtask

  task automatic look(logic [7:0] a, logic [19:0] v, logic [11:0] off, bit wr);
    @(negedge clk);
    lkValid = 1; lkWrite = wr; lkAsid = a; lkVaddr = {v, off};
    #1;
    sHit = lkHit; sFault = lkModFault; sReq = refillReq;
    sPaddr = lkPaddr; sRAsid = refillAsid; sRVpn = refillVpn;
    @(negedge clk); lkValid = 0; lkWrite = 0;
  endtask

  task automatic probe(int s);
    probeSlot = IW'(s); #1;
  endtask

  task automatic tResetState;
    repeat (3) @(negedge clk);
    check("R1", "randomIdx in reset", 64'(randomIdx), 64'(N - 1));
    for (int s = 0; s < N; s += 7) begin
      probe(s);
      check("R1", "slot valid after reset", 64'(probeValid), 0);
      check("R1", "slot ref after reset", 64'(probeRef), 0);
    end
    @(negedge clk); rstN = 1;
  endtask

  task automatic tRandomWalk;
    int r;
    @(negedge clk); r = randomIdx;
    for (int k = 0; k < 40; k++) begin
      int e;
      @(negedge clk);
      e = (r == wiredModel) ? N - 1 : r - 1;
      check("R7", "victim step", 64'(randomIdx), 64'(e));
      r = e;
    end
  endtask

  task automatic tWired;
    setWired(28);
    check("R8", "restart after floor write", 64'(randomIdx), 64'(N - 1));
    @(negedge clk); check("R7", "step 30", 64'(randomIdx), 30);
    @(negedge clk); check("R7", "step 29", 64'(randomIdx), 29);
    @(negedge clk); check("R7", "at floor 28", 64'(randomIdx), 28);
    @(negedge clk); check("R7", "wrap above floor", 64'(randomIdx), 31);
    tRandomWalk();
    setWired(16);
    check("R8", "restart after second floor write", 64'(randomIdx), 64'(N - 1));
  endtask

  task automatic tIndexedInstall;
    setIndex(3);
    install(0, 8'h11, 20'h12345, 20'h00ABC, 1, 1, 0);
    probe(3);
    check("R5", "pointer slot valid", 64'(probeValid), 1);
    check("R5", "pointer slot vpn", 64'(probeVpn), 64'h12345);
    check("R10", "fresh install ref", 64'(probeRef), 0);
    look(8'h11, 20'h12345, 12'h7F0, 0);
    check("R2", "hit", 64'(sHit), 1);
    check("R2", "paddr", 64'(sPaddr), 64'h00ABC7F0);
    check("R4", "no refill on hit", 64'(sReq), 0);
    check("R9", "read never faults", 64'(sFault), 0);
  endtask

  task automatic tAsidGlobal;
    look(8'h22, 20'h12345, 12'h001, 0);
    check("R3", "other tag misses", 64'(sHit), 0);
    check("R4", "refill raised", 64'(sReq), 1);
    check("R4", "refill tag", 64'(sRAsid), 64'h22);
    check("R4", "refill vpn", 64'(sRVpn), 64'h12345);
    setIndex(4);
    install(0, 8'h33, 20'h00777, 20'h55555, 1, 1, 1);
    look(8'h99, 20'h00777, 12'hABC, 0);
    check("R3", "global hits any tag", 64'(sHit), 1);
    check("R3", "global paddr", 64'(sPaddr), 64'h55555ABC);
  endtask

  task automatic tIdle;
    @(negedge clk); lkValid = 0; lkAsid = 8'h11; lkVaddr = {20'h12345, 12'h0}; #1;
    check("R4", "idle no refill", 64'(refillReq), 0);
    check("R4", "idle no hit", 64'(lkHit), 0);
  endtask

  task automatic tRandomInstall;
    int r;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      r = randomIdx;
      insEn = 1; insRandom = 1; insAsid = 8'h44; insVpn = 20'h0BEE0 + 20'(k);
      insPpn = 20'h0CAF0 + 20'(k); insValid = 1; insDirty = 1; insGlobal = 0;
      @(negedge clk); insEn = 0; insRandom = 0;
      probe(r);
      check("R6", "victim slot vpn", 64'(probeVpn), 64'(20'h0BEE0 + 20'(k)));
      check("R6", "victim slot valid", 64'(probeValid), 1);
      repeat (k + 2) @(negedge clk);
    end
  endtask

  task automatic tModFault;
    setIndex(6);
    install(0, 8'h11, 20'h00600, 20'h00066, 1, 0, 0);
    look(8'h11, 20'h00600, 12'h010, 1);
    check("R9", "fault on clean write", 64'(sFault), 1);
    check("R9", "hit kept on fault", 64'(sHit), 1);
    probe(6);
    check("R9", "fault leaves ref clear", 64'(probeRef), 0);
    look(8'h11, 20'h00600, 12'h010, 0);
    check("R9", "clean read no fault", 64'(sFault), 0);
    probe(6);
    check("R10", "completed access sets ref", 64'(probeRef), 1);
  endtask

  task automatic tRefBits;
    probe(3);
    check("R10", "earlier read set ref", 64'(probeRef), 1);
    @(negedge clk); refClear = 1;
    @(negedge clk); refClear = 0;
    probe(3); check("R11", "clear slot 3", 64'(probeRef), 0);
    probe(6); check("R11", "clear slot 6", 64'(probeRef), 0);
    @(negedge clk);
    refClear = 1; lkValid = 1; lkWrite = 0; lkAsid = 8'h11; lkVaddr = {20'h12345, 12'h0};
    @(negedge clk); refClear = 0; lkValid = 0;
    probe(3); check("R11", "clear beats same-cycle access", 64'(probeRef), 0);
    look(8'h11, 20'h12345, 12'h0, 0);
    probe(3); check("R10", "ref set again", 64'(probeRef), 1);
    setIndex(3);
    install(0, 8'h11, 20'h12345, 20'h00ABC, 1, 1, 0);
    probe(3); check("R10", "reinstall clears ref", 64'(probeRef), 0);
  endtask

  task automatic tInvalid;
    setIndex(7);
    install(0, 8'h11, 20'h00700, 20'h00077, 0, 1, 1);
    look(8'h11, 20'h00700, 12'h0, 0);
    check("R12", "invalid slot misses", 64'(sHit), 0);
    check("R12", "invalid slot refills", 64'(sReq), 1);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    tResetState();
    tRandomWalk();
    tIndexedInstall();
    tAsidGlobal();
    tIdle();
    tWired();
    tRandomInstall();
    tModFault();
    tRefBits();
    tInvalid();
    repeat (2) @(negedge clk);
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end
endmodule